// File: doc/BRIEF.md
# Eight-Lane Parallel LED Strip Transmitter

This block sends serial data to eight chains of WS2811-style addressable LEDs at the same time. Every bit cell has three timed events that act on all lanes together. At the start of the cell every lane goes high. At an early threshold the current byte is applied as a mask, so lanes whose bit is 0 drop and lanes whose bit is 1 stay high. At a late threshold every lane is forced low. A lane that drops early sends a short pulse, which the LEDs read as a 0. A lane that stays high until the late point sends a long pulse, which they read as a 1.

Bytes come in on a valid/ready stream. Each byte holds one bit for each lane, and one byte is taken per cell. A start request launches a frame of `frameLen` cells. The request is accepted only while the block is idle, and the frame begins at a fresh cell boundary. After the last cell the block pulses `done`. It then keeps `busy` high through a programmable reset gap, so the LEDs can latch their data before another frame is accepted.

The cell period is fixed at build time from the clock and bit-rate parameters. The two thresholds are fractions of that period in 1/256 units, and they are captured when a frame starts.

Top module: `octa_ws_tx`

## Requirements
- R1: The cell period is T = (CLK_HZ + RATE_HZ/2) / RATE_HZ clock cycles, and consecutive cells within a frame start exactly T cycles apart.
- R2: The early and late thresholds are (T × fracEarly) >> 8 and (T × fracLate) >> 8 cycles after the cell start. Both fractions are sampled in the cycle the start request is accepted, and changes after that cycle do not affect the running frame.
- R3: In the cycle after the cell start, all eight lanes are high.
- R4: In the cycle after the early threshold, lane i equals bit i of the byte taken for that cell, and it holds that value until the late threshold.
- R5: In the cycle after the late threshold, all eight lanes are low.
- R6: `inReady` is high for exactly one cycle per cell, at the early threshold. A frame runs exactly `frameLen` cells and takes bytes in stream order.
- R7: If `inValid` is low when `inReady` is high, `underrun` pulses for one cycle and that cell's byte is treated as 0x00. No byte is taken from the stream.
- R8: `done` pulses for one cycle right after the final cell ends. `busy` is high in that cycle and in exactly `gapCycles` further cycles, then falls.
- R9: A start request is ignored while `busy` is high or when `frameLen` is 0. An accepted start begins a cell at counter zero.
- R10: While `busy` is low, and throughout the reset gap, all lanes are low.
- R11: After reset, the lanes are low and `busy`, `done`, `inReady` and `underrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to send one frame |
| frameLen | input | LEN_W | Number of cells (bytes) in the frame |
| gapCycles | input | GAP_W | Reset-gap length in cycles |
| fracEarly | input | 8 | Early threshold, in 1/256 of the period |
| fracLate | input | 8 | Late threshold, in 1/256 of the period |
| inData | input | LANES | Stream byte; bit i drives lane i |
| inValid | input | 1 | Stream byte available |
| inReady | output | 1 | Byte taken this cycle if valid |
| lanes | output | LANES | LED data pins |
| busy | output | 1 | Frame or reset gap in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| underrun | output | 1 | One-cycle pulse for a missing byte |

## Verification
The bench builds the block with CLK_HZ = 16 MHz and RATE_HZ = 800 kHz, which gives a 20-cycle cell. With that period, the usual 23 %/69 % fractions land on cycles 4 and 13, and the alternative 128/200 fractions land on cycles 10 and 15. Every cell can therefore be followed edge by edge in a short run. The short cell also makes it cheap to test a zero-length reset gap next to a 30-cycle one, a starved stream, and fraction inputs that change in the middle of a frame.

// File: rtl/octa_ws_pkg.sv
package octa_ws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } txState_t;

  // phase strobes from control to datapath
  typedef struct packed {
    logic setAll;
    logic applyMask;
    logic clearAll;
  } phaseStrobe_t;

endpackage

// File: rtl/octa_ws_ctrl.sv
module octa_ws_ctrl
  import octa_ws_pkg::*;
#(
  parameter int CLK_HZ  = 200_000_000,
  parameter int RATE_HZ = 800_000,
  parameter int LEN_W   = 16,
  parameter int GAP_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [LEN_W-1:0] frameLen,
  input  logic [GAP_W-1:0] gapCycles,
  input  logic [7:0]       fracEarly,
  input  logic [7:0]       fracLate,
  input  logic             inValid,
  output logic             inReady,
  output phaseStrobe_t     stb,
  output logic             busy,
  output logic             done,
  output logic             underrun
);
  localparam int PERIOD = (CLK_HZ + RATE_HZ / 2) / RATE_HZ;
  localparam int CNT_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  txState_t         state;
  logic [CNT_W-1:0] cnt, thrE, thrL;
  logic [LEN_W-1:0] cellsLeft;
  logic [GAP_W-1:0] gapCnt, gapLen;
  logic             doneQ, underrunQ;

  function automatic logic [CNT_W-1:0] calcThr(input logic [7:0] frac);
    logic [31:0] prod;
    prod = 32'(PERIOD) * {24'd0, frac};
    return CNT_W'(prod >> 8);
  endfunction

  logic running;
  assign running       = (state == ST_RUN);
  assign stb.setAll    = running && (cnt == '0);
  assign stb.applyMask = running && (cnt == thrE);
  assign stb.clearAll  = running && (cnt == thrL);
  assign inReady       = stb.applyMask;
  assign busy          = (state != ST_IDLE);
  assign done          = doneQ;
  assign underrun      = underrunQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      thrE      <= '0;
      thrL      <= '0;
      cellsLeft <= '0;
      gapCnt    <= '0;
      gapLen    <= '0;
      doneQ     <= 1'b0;
      underrunQ <= 1'b0;
    end else begin
      doneQ     <= 1'b0;
      underrunQ <= stb.applyMask && !inValid;
      case (state)
        ST_IDLE: begin
          if (startReq && (frameLen != '0)) begin
            state     <= ST_RUN;
            cnt       <= '0;
            cellsLeft <= frameLen;
            gapLen    <= gapCycles;
            thrE      <= calcThr(fracEarly);
            thrL      <= calcThr(fracLate);
          end
        end
        ST_RUN: begin
          if (cnt == LAST) begin
            cnt <= '0;
            if (cellsLeft == LEN_W'(1)) begin
              state  <= ST_GAP;
              gapCnt <= '0;
              doneQ  <= 1'b1;
            end else begin
              cellsLeft <= cellsLeft - 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gapCnt == gapLen) state <= ST_IDLE;
          else gapCnt <= gapCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    running |-> cnt <= LAST);
  p_ready_only_running_r6: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> state == ST_RUN);
  p_ready_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> !inReady);
  p_done_after_run_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (state == ST_GAP) && ($past(state) == ST_RUN));
  p_start_aligned_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) ##1 (state == ST_RUN) |-> cnt == '0);
endmodule

// File: rtl/octa_ws_datapath.sv
module octa_ws_datapath
  import octa_ws_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  phaseStrobe_t     stb,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] lanes
);
  logic [LANES-1:0] afterSet, afterMask, laneNext;

  // events combine in order: set, apply, clear
  always_comb begin
    afterSet  = stb.setAll ? {LANES{1'b1}} : lanes;
    afterMask = stb.applyMask ? (afterSet & mask) : afterSet;
    laneNext  = stb.clearAll ? '0 : afterMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lanes <= '0;
    else       lanes <= laneNext;
  end

  p_clear_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAll |=> lanes == '0);
  p_set_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setAll && !stb.applyMask && !stb.clearAll) |=> &lanes);
  p_mask_only_drops_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.applyMask && !stb.setAll && !stb.clearAll) |=> (lanes & ~$past(lanes)) == '0);
endmodule

// File: rtl/octa_ws_tx.sv
module octa_ws_tx
  import octa_ws_pkg::*;
#(
  parameter int CLK_HZ  = 200_000_000,
  parameter int RATE_HZ = 800_000,
  parameter int LANES   = 8,
  parameter int LEN_W   = 16,
  parameter int GAP_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [LEN_W-1:0] frameLen,
  input  logic [GAP_W-1:0] gapCycles,
  input  logic [7:0]       fracEarly,
  input  logic [7:0]       fracLate,
  input  logic [LANES-1:0] inData,
  input  logic             inValid,
  output logic             inReady,
  output logic [LANES-1:0] lanes,
  output logic             busy,
  output logic             done,
  output logic             underrun
);
  phaseStrobe_t     stb;
  logic [LANES-1:0] mask;

  assign mask = inValid ? inData : '0;

  octa_ws_ctrl #(
    .CLK_HZ(CLK_HZ), .RATE_HZ(RATE_HZ), .LEN_W(LEN_W), .GAP_W(GAP_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .frameLen(frameLen),
    .gapCycles(gapCycles), .fracEarly(fracEarly), .fracLate(fracLate),
    .inValid(inValid), .inReady(inReady), .stb(stb), .busy(busy),
    .done(done), .underrun(underrun)
  );

  octa_ws_datapath #(.LANES(LANES)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .mask(mask), .lanes(lanes)
  );

  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> lanes == '0);
  p_underrun_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> lanes == '0);
endmodule

// File: tb/octa_ws_tx_test.sv
module octa_ws_tx_test;
  localparam int CLK_HZ  = 16_000_000;
  localparam int RATE_HZ = 800_000;
  localparam int T       = (CLK_HZ + RATE_HZ / 2) / RATE_HZ;

  typedef struct {
    logic [7:0] data;
    bit         first;
    int         thrE;
    int         thrL;
  } cell_t;

  logic        clk = 0, rstN = 0, startReq = 0, inValid = 0;
  logic [15:0] frameLen = 0, gapCycles = 0;
  logic [7:0]  fracEarly = 0, fracLate = 0, inData = 0;
  logic        inReady, busy, done, underrun;
  logic [7:0]  lanes;

  int checks = 0, errors = 0, cyc = 0, lastStart = 0;
  int cellsSeen = 0, readyCnt = 0, underrunCnt = 0;
  bit starve = 0, fire = 0;
  cell_t expQ[$];
  logic [7:0] srcQ[$];

  octa_ws_tx #(.CLK_HZ(CLK_HZ), .RATE_HZ(RATE_HZ)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .frameLen(frameLen),
    .gapCycles(gapCycles), .fracEarly(fracEarly), .fracLate(fracLate),
    .inData(inData), .inValid(inValid), .inReady(inReady), .lanes(lanes),
    .busy(busy), .done(done), .underrun(underrun)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // stream source
  always @(negedge clk) begin
    fire = inReady && inValid;
    if (inReady) readyCnt++;
    if (underrun) underrunCnt++;
  end
  initial begin
    forever begin
      @(posedge clk); #1;
      if (fire && srcQ.size() != 0) void'(srcQ.pop_front());
      inValid = (srcQ.size() != 0) && !starve;
      inData  = (srcQ.size() != 0) ? srcQ[0] : 8'h00;
    end
  end

  // monitor: scoreboard of cells
  initial begin
    logic [7:0] prevL;
    cell_t it;
    prevL = 0;
    forever begin
      @(negedge clk);
      if (rstN && busy && prevL == 8'h00 && lanes == 8'hFF) begin
        if (expQ.size() == 0) begin
          check(0, "R6 unexpected cell", 1, 0);
        end else begin
          it = expQ.pop_front();
          cellsSeen++;
          if (!it.first) check(cyc - lastStart == T, "R1 cell spacing", cyc - lastStart, T);
          lastStart = cyc;
          repeat (it.thrE - 1) @(negedge clk);
          check(lanes == 8'hFF, "R3 high before early point", lanes, 8'hFF);
          @(negedge clk);
          check(lanes == it.data, "R4 data at early point", lanes, it.data);
          repeat (it.thrL - it.thrE - 1) @(negedge clk);
          check(lanes == it.data, "R4 data held to late point", lanes, it.data);
          @(negedge clk);
          check(lanes == 8'h00, "R5 low after late point", lanes, 0);
        end
      end
      prevL = lanes;
    end
  end

  task automatic sendFrame(input logic [7:0] bytes[$], input int fe, input int fl,
                           input int gap, input bit noData);
    int te, tl, n, waitCnt;
    te = (T * fe) >> 8;
    tl = (T * fl) >> 8;
    for (int i = 0; i < bytes.size(); i++) begin
      if (!noData) srcQ.push_back(bytes[i]);
      expQ.push_back('{noData ? 8'h00 : bytes[i], i == 0, te, tl});
    end
    starve = noData;
    @(negedge clk);
    frameLen = 16'(bytes.size()); gapCycles = 16'(gap);
    fracEarly = 8'(fe); fracLate = 8'(fl);
    readyCnt = 0; underrunCnt = 0; cellsSeen = 0;
    startReq = 1;
    @(negedge clk);
    startReq = 0;
    fracEarly = 8'd20; fracLate = 8'd240;   // R2: changes after start must not matter
    waitCnt = 0;
    while (!done && waitCnt < 5000) begin @(negedge clk); waitCnt++; end
    check(done == 1, "R8 done seen", done, 1);
    check(busy == 1, "R8 busy in done cycle", busy, 1);
    // try a start inside the gap (R9)
    startReq = 1; frameLen = 16'd3;
    n = 0;
    @(negedge clk);
    startReq = 0;
    check(done == 0, "R8 done one cycle", done, 0);
    while (busy && n < 5000) begin
      n++;
      check(lanes == 8'h00, "R10 lanes low in gap", lanes, 0);
      @(negedge clk);
    end
    check(n == gap, "R8 gap length", n, gap);
    check(expQ.size() == 0, "R6 all cells sent", expQ.size(), 0);
    check(cellsSeen == bytes.size(), "R6 cell count", cellsSeen, bytes.size());
    check(readyCnt == bytes.size(), "R6 ready pulses", readyCnt, bytes.size());
    check(underrunCnt == (noData ? bytes.size() : 0), "R7 underrun count",
          underrunCnt, noData ? bytes.size() : 0);
    repeat (3) @(negedge clk);
    check(busy == 0, "R9 start during gap ignored", busy, 0);
    check(lanes == 8'h00, "R10 lanes low idle", lanes, 0);
    starve = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(lanes == 0, "R11 lanes", lanes, 0);
    check(busy == 0 && done == 0, "R11 busy/done", {busy, done}, 0);
    check(inReady == 0 && underrun == 0, "R11 ready/underrun", {inReady, underrun}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(T == 20, "R1 period", T, 20);
    sendFrame('{8'hA5, 8'h3C, 8'hFF, 8'h01}, 59, 177, 30, 0);
    sendFrame('{8'h5A, 8'h00, 8'h81}, 128, 200, 0, 0);
    sendFrame('{8'hF0, 8'h0F}, 59, 177, 5, 1);
    check(srcQ.size() == 0, "R7 no byte taken on underrun", srcQ.size(), 0);
    // R9: zero-length frame ignored
    @(negedge clk);
    frameLen = 0; startReq = 1;
    @(negedge clk);
    startReq = 0;
    repeat (2) begin
      check(busy == 0, "R9 zero length ignored", busy, 0);
      @(negedge clk);
    end
    sendFrame('{8'h96}, 59, 177, 2, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule